// File: doc/BRIEF.md
# DMA Channel Start-Request Controller

This block decides when each of four DMA channels may begin a transfer cycle. Every channel holds an enable bit, a terminal-count flag, a block count and a trigger selector. A cycle can be started in two ways. Software writes a start bit, or a rising edge arrives on the peripheral interrupt line that the channel's selector names. A started channel raises its transfer request toward the transfer engine. It stays busy until the engine returns a one-clock done pulse.

Requests that reach a busy channel are dropped, not queued. A software and a hardware request that land on the same channel in the same clock produce a single cycle, and the hardware source is recorded. Each completed cycle lowers the block count by one. When the count steps from 1 to 0, the channel disables itself, latches its terminal-count flag and gives a one-clock completion interrupt. Writing the enable bit to 1 re-arms the channel and clears the flag. Software can watch the block count to tell that a cycle has finished before it triggers the next one.

Top module: `dma_start_ctl`

## Requirements
- R1: After reset every channel has enable 0, terminal flag 0, request 0, source 0, block count 0 and interrupt 0, and its trigger selector is 0.
- R2: A control write (wr_ctl) to a channel takes wr_data bit 0 as the new enable bit and wr_data bit 1 as a start strobe. The start bit is not stored. A strobe of 1 to an eligible idle channel sets xfer_req on the next clock with xfer_hw 0. A further cycle needs another write.
- R3: The trigger selector is loaded from wr_data[3:0] by wr_trig. A value s in 1..15 makes a rising edge on periph_irq[s-1] start the channel, with xfer_hw set to 1. A held high level starts it only once, and selector value 0 never starts it.
- R4: A channel is eligible only if enable is 1 and the terminal flag is 0, both taken after any control write in the same clock. Otherwise requests are ignored.
- R5: A software or hardware request that arrives while xfer_req is 1 is discarded. It does not start a cycle after the done pulse.
- R6: A software and a hardware request in the same clock start exactly one cycle, and xfer_hw is 1.
- R7: xfer_done with xfer_req high clears xfer_req and lowers the block count by 1 on the next clock. xfer_done with xfer_req low has no effect. wr_cnt loads the count from wr_data.
- R8: A completion that moves the count from 1 to 0 clears enable, sets the terminal flag and pulses dma_irq for exactly one clock. The terminal step takes priority over a control write in the same clock.
- R9: A control write with bit 0 = 1 clears the terminal flag. Without such a write the flag stays set.
- R10: The channels are independent: activity on one never changes the state or outputs of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_ctl | input | 1 | Control write strobe (bit 0 enable, bit 1 start) |
| wr_cnt | input | 1 | Block count load strobe |
| wr_trig | input | 1 | Trigger selector load strobe |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_data | input | 16 | Write data |
| periph_irq | input | 15 | Peripheral interrupt lines |
| xfer_done | input | 4 | Per-channel transfer completion pulse |
| xfer_req | output | 4 | Channel busy / transfer request |
| xfer_hw | output | 4 | Current cycle started by hardware trigger |
| ch_en | output | 4 | Enable bits |
| ch_tc | output | 4 | Terminal-count flags |
| blk_cnt | output | 64 | Block counts, channel n at bits 16n+15:16n |
| dma_irq | output | 4 | Completion interrupt pulses |

## Verification
The hardest case to reach is a software strobe and a selected peripheral edge that land on the same idle, eligible channel in one clock. In that case the two requests must merge into one cycle with the hardware source recorded. The random phase only rarely lines these up, so a directed sequence sets the selector, pre-lowers the line, and then raises the line together with the control write. A second directed sequence holds a channel busy while both sources fire, to show that nothing is left pending once the done pulse returns.

// File: rtl/dma_start_ctl.sv
module dma_start_ctl #(
  parameter int NCH     = 4,
  parameter int NPERIPH = 15,
  parameter int CNTW    = 16,
  localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int SELW   = $clog2(NPERIPH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_ctl,
  input  logic                wr_cnt,
  input  logic                wr_trig,
  input  logic [CHW-1:0]      wr_ch,
  input  logic [CNTW-1:0]     wr_data,
  input  logic [NPERIPH-1:0]  periph_irq,
  input  logic [NCH-1:0]      xfer_done,
  output logic [NCH-1:0]      xfer_req,
  output logic [NCH-1:0]      xfer_hw,
  output logic [NCH-1:0]      ch_en,
  output logic [NCH-1:0]      ch_tc,
  output logic [NCH*CNTW-1:0] blk_cnt,
  output logic [NCH-1:0]      dma_irq
);

  logic [NPERIPH-1:0] irq_q;
  logic [NPERIPH:0]   irq_edge;

  assign irq_edge = {periph_irq & ~irq_q, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= '0;
    else        irq_q <= periph_irq;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [SELW-1:0] sel;
    logic [CNTW-1:0] cnt;
    logic            en, tc, busy, src, irq;

    wire hit   = (wr_ch == CHW'(g));
    wire ctl_w = wr_ctl && hit;
    wire en_w  = ctl_w ? wr_data[0] : en;
    wire tc_w  = tc && !(ctl_w && wr_data[0]);
    wire hw    = irq_edge[sel];
    wire sw    = ctl_w && wr_data[1];
    wire go    = (hw || sw) && en_w && !tc_w && !busy;
    wire fin   = busy && xfer_done[g];
    wire last  = fin && (cnt == CNTW'(1));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sel  <= '0;
        cnt  <= '0;
        en   <= 1'b0;
        tc   <= 1'b0;
        busy <= 1'b0;
        src  <= 1'b0;
        irq  <= 1'b0;
      end else begin
        en  <= en_w && !last;
        tc  <= tc_w || last;
        irq <= last;
        if (go) begin
          busy <= 1'b1;
          src  <= hw;
        end else if (fin) begin
          busy <= 1'b0;
        end
        if (wr_cnt && hit) cnt <= wr_data;
        else if (fin)      cnt <= cnt - CNTW'(1);
        if (wr_trig && hit) sel <= wr_data[SELW-1:0];
      end
    end

    assign xfer_req[g]              = busy;
    assign xfer_hw[g]               = src;
    assign ch_en[g]                 = en;
    assign ch_tc[g]                 = tc;
    assign dma_irq[g]               = irq;
    assign blk_cnt[g*CNTW +: CNTW]  = cnt;
  end

endmodule

// File: rtl/dma_start_ctl_chk.sv
module dma_start_ctl_chk #(
  parameter int NCH     = 4,
  parameter int NPERIPH = 15,
  parameter int CNTW    = 16,
  localparam int CHW    = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_ctl,
  input logic                wr_cnt,
  input logic [CHW-1:0]      wr_ch,
  input logic [CNTW-1:0]     wr_data,
  input logic [NCH-1:0]      xfer_done,
  input logic [NCH-1:0]      xfer_req,
  input logic [NCH-1:0]      ch_en,
  input logic [NCH-1:0]      ch_tc,
  input logic [NCH*CNTW-1:0] blk_cnt,
  input logic [NCH-1:0]      dma_irq
);

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    wire hit = (wr_ch == CHW'(g));

    // R8: completion interrupt lasts one clock
    a_r8_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      dma_irq[g] |=> !dma_irq[g]);

    // R8: interrupt coincides with disabled channel and set flag
    a_r8_irq_state: assert property (@(posedge clk) disable iff (!rst_n)
      dma_irq[g] |-> (ch_tc[g] && !ch_en[g]));

    // R5: a busy channel stays busy until its done pulse
    a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req[g] && !xfer_done[g]) |=> xfer_req[g]);

    // R4: disabled channel without an enabling write never starts
    a_r4_no_start: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_req[g] && !ch_en[g] && !(wr_ctl && hit && wr_data[0])) |=> !xfer_req[g]);

    // R7: completion lowers the block count by one
    a_r7_cnt_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req[g] && xfer_done[g] && !(wr_cnt && hit))
        |=> (blk_cnt[g*CNTW +: CNTW] == $past(blk_cnt[g*CNTW +: CNTW]) - CNTW'(1)));

    // R9: flag stays set unless re-enabled
    a_r9_tc_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_tc[g] && !(wr_ctl && hit && wr_data[0])) |=> ch_tc[g]);
  end

endmodule

bind dma_start_ctl dma_start_ctl_chk #(.NCH(NCH), .NPERIPH(NPERIPH), .CNTW(CNTW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_cnt(wr_cnt), .wr_ch(wr_ch),
  .wr_data(wr_data), .xfer_done(xfer_done), .xfer_req(xfer_req), .ch_en(ch_en),
  .ch_tc(ch_tc), .blk_cnt(blk_cnt), .dma_irq(dma_irq)
);

// File: tb/dma_start_ctl_tb_top.sv
module dma_start_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;
  localparam int NP  = 15;
  localparam int CW  = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_ctl = 0, wr_cnt = 0, wr_trig = 0;
  logic [1:0]    wr_ch = '0;
  logic [CW-1:0] wr_data = '0;
  logic [NP-1:0] periph_irq = '0;
  logic [NCH-1:0] xfer_done = '0;
  logic [NCH-1:0] xfer_req, xfer_hw, ch_en, ch_tc, dma_irq;
  logic [NCH*CW-1:0] blk_cnt;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic          m_en[NCH], m_tc[NCH], m_busy[NCH], m_src[NCH], m_irq[NCH];
  logic [CW-1:0] m_cnt[NCH];
  logic [3:0]    m_sel[NCH];
  logic [NP-1:0] m_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_start_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .wr_ctl(wr_ctl), .wr_cnt(wr_cnt), .wr_trig(wr_trig),
    .wr_ch(wr_ch), .wr_data(wr_data), .periph_irq(periph_irq), .xfer_done(xfer_done),
    .xfer_req(xfer_req), .xfer_hw(xfer_hw), .ch_en(ch_en), .ch_tc(ch_tc),
    .blk_cnt(blk_cnt), .dma_irq(dma_irq)
  );

  function automatic logic [3:0] pack_bits(input int i);
    return {m_irq[i], m_src[i], m_tc[i], m_en[i]};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NCH; i++) begin
      m_en[i] = 0; m_tc[i] = 0; m_busy[i] = 0; m_src[i] = 0; m_irq[i] = 0;
      m_cnt[i] = '0; m_sel[i] = '0;
    end
    m_prev = '0;
  endtask

  task automatic model_step();
    for (int i = 0; i < NCH; i++) begin
      logic hitc, ew, tw, sw, hw, ok, fin, last;
      hitc = (wr_ch == 2'(i));
      ew   = (wr_ctl && hitc) ? wr_data[0] : m_en[i];
      tw   = m_tc[i] && !(wr_ctl && hitc && wr_data[0]);
      sw   = wr_ctl && hitc && wr_data[1];
      hw   = (m_sel[i] != 0) && periph_irq[m_sel[i]-1] && !m_prev[m_sel[i]-1];
      ok   = ew && !tw && !m_busy[i];
      fin  = m_busy[i] && xfer_done[i];
      last = fin && (m_cnt[i] == 1);
      m_irq[i] = last;
      if (ok && (sw || hw)) begin m_busy[i] = 1; m_src[i] = hw; end
      else if (fin) m_busy[i] = 0;
      if (fin) m_cnt[i] = m_cnt[i] - 1;
      if (wr_cnt && hitc) m_cnt[i] = wr_data;
      if (wr_trig && hitc) m_sel[i] = wr_data[3:0];
      m_en[i] = ew && !last;
      m_tc[i] = tw || last;
    end
    m_prev = periph_irq;
  endtask

  task automatic compare(input string tag);
    for (int i = 0; i < NCH; i++) begin
      logic [3:0] act;
      act = {dma_irq[i], xfer_hw[i], ch_tc[i], ch_en[i]};
      total++;
      if (xfer_req[i] !== m_busy[i]) begin
        bad++; $display("FAIL %s ch%0d xfer_req act=%0b exp=%0b", tag, i, xfer_req[i], m_busy[i]);
      end
      total++;
      if (act !== pack_bits(i)) begin
        bad++; $display("FAIL %s ch%0d irq/hw/tc/en act=%b exp=%b", tag, i, act, pack_bits(i));
      end
      total++;
      if (blk_cnt[i*CW +: CW] !== m_cnt[i]) begin
        bad++; $display("FAIL %s ch%0d blk_cnt act=%0d exp=%0d", tag, i, blk_cnt[i*CW +: CW], m_cnt[i]);
      end
    end
  endtask

  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    wr_ctl = 0; wr_cnt = 0; wr_trig = 0; xfer_done = '0;
    compare(tag);
  endtask

  task automatic expect_bit(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++; $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic w_ctl(input int ch, input logic en, input logic st);
    wr_ctl = 1; wr_ch = 2'(ch); wr_data = {14'd0, st, en};
  endtask
  task automatic w_cnt(input int ch, input int v);
    wr_cnt = 1; wr_ch = 2'(ch); wr_data = CW'(v);
  endtask
  task automatic w_trig(input int ch, input int v);
    wr_trig = 1; wr_ch = 2'(ch); wr_data = CW'(v);
  endtask

  initial begin
    void'($urandom(32'h5eed_d4a1));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    compare("R1 reset");

    // R2: software start, start not retained
    w_cnt(0, 2); tick("R7 load");
    w_ctl(0, 1, 1); tick("R2 sw start");
    expect_bit("R2 req raised", xfer_req[0], 1'b1);
    xfer_done[0] = 1; tick("R7 done");
    tick("R2 no repeat");
    expect_bit("R2 idle after done", xfer_req[0], 1'b0);

    // R8: terminal count
    w_ctl(0, 1, 1); tick("R2 second start");
    xfer_done[0] = 1; tick("R8 terminal");
    expect_bit("R8 irq pulse", dma_irq[0], 1'b1);
    expect_bit("R8 tc set", ch_tc[0], 1'b1);
    tick("R8 pulse ends");
    expect_bit("R8 irq one clock", dma_irq[0], 1'b0);

    // R4: flag blocks start; R9 re-enable clears flag
    w_ctl(0, 0, 1); tick("R4 blocked");
    expect_bit("R4 no start while tc", xfer_req[0], 1'b0);
    w_ctl(0, 1, 0); tick("R9 clear tc");
    expect_bit("R9 tc cleared", ch_tc[0], 1'b0);

    // R3: hardware trigger, level held, selector 0
    w_cnt(1, 5); tick("R7 load");
    w_ctl(1, 1, 0); tick("R3 enable");
    periph_irq[6] = 1; tick("R3 sel0 ignores");
    expect_bit("R3 sel0 no start", xfer_req[1], 1'b0);
    w_trig(1, 7); tick("R3 sel write");
    tick("R3 level held");
    expect_bit("R3 level no start", xfer_req[1], 1'b0);
    periph_irq[6] = 0; tick("R3 low");
    periph_irq[6] = 1; tick("R3 edge");
    expect_bit("R3 edge starts", xfer_req[1], 1'b1);
    expect_bit("R3 hw source", xfer_hw[1], 1'b1);

    // R5: requests while busy dropped; R10 others untouched
    periph_irq[6] = 0; w_ctl(1, 1, 1); tick("R5 sw while busy");
    periph_irq[6] = 1; tick("R5 hw while busy");
    xfer_done[1] = 1; tick("R5 done");
    tick("R5 nothing pending");
    expect_bit("R5 dropped", xfer_req[1], 1'b0);
    expect_bit("R10 ch2 idle", xfer_req[2], 1'b0);

    // R6: simultaneous sw + hw
    periph_irq[6] = 0; tick("R6 prep");
    periph_irq[6] = 1; w_ctl(1, 1, 1); tick("R6 both");
    expect_bit("R6 one start", xfer_req[1], 1'b1);
    expect_bit("R6 hw wins", xfer_hw[1], 1'b1);
    xfer_done[1] = 1; tick("R6 done");
    xfer_done[1] = 1; tick("R7 done while idle");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      int op;
      op = $urandom_range(0, 9);
      case (op)
        0, 1: w_ctl($urandom_range(0, 3), ($urandom_range(0, 3) != 0), $urandom_range(0, 1));
        2:    w_cnt($urandom_range(0, 3), $urandom_range(0, 4));
        3:    w_trig($urandom_range(0, 3), $urandom_range(0, 15));
        default: ;
      endcase
      periph_irq = periph_irq ^ NP'($urandom() & $urandom());
      xfer_done  = NCH'($urandom() & $urandom());
      tick("R10 random");
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule